// File: doc/BRIEF.md
# Per-Block Write-Protect Lock Controller

This block holds a lock state for every erase block of a flash array and changes those states in response to range commands. A host loads a start and an end block index through two register strobes, then issues one of four command codes: unlock a range, lock a range, make a range lock-tight, or unlock the whole array. The controller walks the selected blocks one per clock, updates each block's state, and mirrors the most recently written state in a small status word. It raises `busy` for the length of the walk and pulses `done` for one cycle when the walk ends.

Lock-tight is sticky: the unlock and lock walks halt when they reach a lock-tight block, and only a cold reset returns such a block to locked. A lock-tight walk leaves unlocked blocks alone and turns every other block in the range lock-tight. If a walk index reaches the block count, the controller raises a command-error flag and ends the walk. A combinational query port lets program and erase gating logic, or a test, read the state of any one block.

Top module: `lockwp_ctrl`

## Requirements
- R1: Block states are one-hot, 3 bits wide: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. `query_state` combinationally returns the state of block `query_idx`, and returns 3'b000 for an index at or above NUM_BLOCKS.
- R2: Cold reset (`rst_n` low, asynchronous) sets every block to locked and `wp_status` to 3'b010. It also clears `range_start`, `range_end`, `busy`, `done` and `cmd_err`.
- R3: When idle, a `start_wr` strobe stores the low ADDR_W bits of `wr_data` into both `range_start` and `range_end`. An `end_wr` strobe stores them into `range_end` only. For a power-of-two block count this equals masking with the block count minus 1. Range strobes are ignored while `busy` is high.
- R4: Command codes are 8'h23 (unlock range), 8'h2A (lock range), 8'h2C (lock-tight range) and 8'h27 (unlock all). Any other code is ignored: `busy` stays low and no state changes.
- R5: Unlock-range and lock-range visit the blocks from `range_start` to `range_end` inclusive, one per clock. Each visited block is set to unlocked or locked. The walk ends at the first lock-tight block and leaves that block and every later block unchanged.
- R6: Lock-tight-range visits the same range without stopping early. It skips unlocked blocks and sets every locked or lock-tight block to lock-tight.
- R7: Unlock-all visits blocks 0 to NUM_BLOCKS-1 and behaves like unlock-range, including the stop at the first lock-tight block.
- R8: When the walk index reaches NUM_BLOCKS before passing `range_end`, `cmd_err` is set and the walk ends. Acceptance of the next command clears `cmd_err`.
- R9: Every block write copies the new state into `wp_status`. Skipped blocks, the stopping block and ignored commands leave `wp_status` unchanged.
- R10: A command accepted at clock edge k raises `busy` from edge k. Each later edge handles one index position: an update, a skip, the stopping block, the overflow index, or an empty range when start > end. At the edge that handles the final position, `busy` falls and `done` goes high for exactly one cycle.
- R11: A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| start_wr | input | 1 | Strobe: load range start (and end) from wr_data |
| end_wr | input | 1 | Strobe: load range end from wr_data |
| wr_data | input | DATA_W | Data for range strobes |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| query_idx | input | ADDR_W | Block index to inspect |
| query_state | output | 3 | One-hot state of block query_idx |
| range_start | output | ADDR_W | Current range start register |
| range_end | output | ADDR_W | Current range end register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| cmd_err | output | 1 | Walk index reached the block count |
| wp_status | output | 3 | State most recently written to any block |

## Verification
On every cycle the assertions check several local properties. Queried states are one-hot, and no write turns a lock-tight block into anything else. `done` is a single-cycle pulse that coincides with the fall of `busy`. A start strobe leaves end equal to start, the range registers hold still during a walk, `cmd_err` rises only at the end of a walk, and `wp_status` follows each block write. The bench scenarios show the properties that span a whole walk. These include where an unlock walk stops at a lock-tight block, which blocks a lock-tight walk skips, and overflow past the block count. They also include the exact walk length, the clearing of the error on the next command, and that unknown codes and commands issued during a walk have no effect.

// File: rtl/lockwp_pkg.sv
package lockwp_pkg;

    // One-hot per-block protection states
    localparam logic [2:0] LK_TIGHT = 3'b001;
    localparam logic [2:0] LK_HELD  = 3'b010;
    localparam logic [2:0] LK_OPEN  = 3'b100;

    // Command codes seen at the command strobe
    localparam logic [7:0] CODE_UNLOCK     = 8'h23;
    localparam logic [7:0] CODE_UNLOCK_ALL = 8'h27;
    localparam logic [7:0] CODE_LOCK       = 8'h2A;
    localparam logic [7:0] CODE_TIGHT      = 8'h2C;

    typedef enum logic [1:0] {
        OP_UNLOCK     = 2'd0,
        OP_LOCK       = 2'd1,
        OP_TIGHT      = 2'd2,
        OP_UNLOCK_ALL = 2'd3
    } walk_op_e;

    function automatic logic code_known(input logic [7:0] c);
        return (c == CODE_UNLOCK) || (c == CODE_UNLOCK_ALL) ||
               (c == CODE_LOCK)   || (c == CODE_TIGHT);
    endfunction

    function automatic walk_op_e code_to_op(input logic [7:0] c);
        walk_op_e op;
        unique case (c)
            CODE_LOCK:       op = OP_LOCK;
            CODE_TIGHT:      op = OP_TIGHT;
            CODE_UNLOCK_ALL: op = OP_UNLOCK_ALL;
            default:         op = OP_UNLOCK;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/lockwp_range_regs.sv
module lockwp_range_regs #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic [ADDR_W-1:0] range_start,
    output logic [ADDR_W-1:0] range_end
);

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } range_t;

    range_t q, d;

    // Upper data bits carry no meaning for the range registers
    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:ADDR_W];

    always_comb begin
        d = q;
        if (!busy) begin
            if (start_wr) begin
                d.first = wr_data[ADDR_W-1:0];
                d.last  = wr_data[ADDR_W-1:0];
            end
            if (end_wr) begin
                d.last = wr_data[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign range_start = q.first;
    assign range_end   = q.last;

    assert_start_mirrors_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !busy) |=> (range_end == range_start));

    assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(range_start) && $stable(range_end)));

endmodule

// File: rtl/lockwp_table.sv
module lockwp_table #(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [2:0]        wr_state,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [2:0]        rd_state,
    input  logic [ADDR_W-1:0] q_idx,
    output logic [2:0]        q_state
);
    import lockwp_pkg::*;

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_BLOCKS);
    localparam logic [NUM_BLOCKS*3-1:0] COLD_VAL = {NUM_BLOCKS{LK_HELD}};

    typedef struct packed {
        logic [NUM_BLOCKS-1:0][2:0] st;
    } table_t;

    table_t q, d;

    always_comb begin
        d = q;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (wr_en && ({1'b0, wr_idx} == CNT_W'(b))) begin
                d.st[b] = wr_state;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= COLD_VAL;
        else        q <= d;
    end

    always_comb begin
        rd_state = 3'b000;
        q_state  = 3'b000;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if ({1'b0, rd_idx} == CNT_W'(b)) rd_state = q.st[b];
            if ({1'b0, q_idx}  == CNT_W'(b)) q_state  = q.st[b];
        end
    end

    assert_query_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, q_idx} < LIMIT) |-> $onehot(q_state));

    // Lock-tight is sticky: a write may only land on it with lock-tight again
    assert_tight_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx && rd_state == LK_TIGHT) |-> (wr_state == LK_TIGHT));

endmodule

// File: rtl/lockwp_sequencer.sv
module lockwp_sequencer #(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] range_start,
    input  logic [ADDR_W-1:0] range_end,
    input  logic [2:0]        cur_state,
    output logic [ADDR_W-1:0] walk_idx,
    output logic              wr_en,
    output logic [2:0]        wr_state,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        wp_status
);
    import lockwp_pkg::*;

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0]  LIMIT    = CNT_W'(NUM_BLOCKS);
    localparam logic [ADDR_W-1:0] LAST_BLK = ADDR_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              err;
        walk_op_e          op;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] lim;
        logic [2:0]        wp;
    } seq_t;

    seq_t q, d;
    logic finish;
    logic at_last;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        wr_en    = 1'b0;
        wr_state = 3'b000;
        finish   = 1'b0;
        at_last  = (q.idx == q.lim);
        if (!q.busy) begin
            if (cmd_valid && code_known(cmd_code)) begin
                d.busy = 1'b1;
                d.err  = 1'b0;
                d.op   = code_to_op(cmd_code);
                if (code_to_op(cmd_code) == OP_UNLOCK_ALL) begin
                    d.idx = '0;
                    d.lim = LAST_BLK;
                end else begin
                    d.idx = range_start;
                    d.lim = range_end;
                end
            end
        end else begin
            if (q.idx > q.lim) begin
                finish = 1'b1;                    // empty range
            end else if ({1'b0, q.idx} >= LIMIT) begin
                d.err  = 1'b1;                    // walked off the array
                finish = 1'b1;
            end else begin
                unique case (q.op)
                    OP_TIGHT: begin
                        if (cur_state != LK_OPEN) begin
                            wr_en    = 1'b1;
                            wr_state = LK_TIGHT;
                        end
                        finish = at_last;
                    end
                    default: begin
                        if (cur_state == LK_TIGHT) begin
                            finish = 1'b1;
                        end else begin
                            wr_en    = 1'b1;
                            wr_state = (q.op == OP_LOCK) ? LK_HELD : LK_OPEN;
                            finish   = at_last;
                        end
                    end
                endcase
                d.idx = q.idx + 1'b1;
                if (wr_en) d.wp = wr_state;
            end
            if (finish) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.op   <= OP_UNLOCK;
            q.wp   <= LK_HELD;
        end else begin
            q <= d;
        end
    end

    assign walk_idx  = q.idx;
    assign busy      = q.busy;
    assign done      = q.done;
    assign cmd_err   = q.err;
    assign wp_status = q.wp;

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_err_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> done);

    assert_wp_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wp_status == $past(wr_state)));

    assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

endmodule

// File: rtl/lockwp_ctrl.sv
module lockwp_ctrl #(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] query_idx,
    output logic [2:0]        query_state,
    output logic [ADDR_W-1:0] range_start,
    output logic [ADDR_W-1:0] range_end,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        wp_status
);

    logic [ADDR_W-1:0] walk_idx;
    logic [2:0]        cur_state;
    logic              wr_en;
    logic [2:0]        wr_state;

    lockwp_range_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_range (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .end_wr      (end_wr),
        .wr_data     (wr_data),
        .busy        (busy),
        .range_start (range_start),
        .range_end   (range_end)
    );

    lockwp_table #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (walk_idx),
        .wr_state (wr_state),
        .rd_idx   (walk_idx),
        .rd_state (cur_state),
        .q_idx    (query_idx),
        .q_state  (query_state)
    );

    lockwp_sequencer #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .range_start (range_start),
        .range_end   (range_end),
        .cur_state   (cur_state),
        .walk_idx    (walk_idx),
        .wr_en       (wr_en),
        .wr_state    (wr_state),
        .busy        (busy),
        .done        (done),
        .cmd_err     (cmd_err),
        .wp_status   (wp_status)
    );

endmodule

// File: tb/tb_lockwp_ctrl.sv
module tb_lockwp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr = 1'b0;
    logic          end_wr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic [AW-1:0] query_idx = '0;
    logic [2:0]    query_state;
    logic [AW-1:0] range_start, range_end;
    logic          busy, done, cmd_err;
    logic [2:0]    wp_status;

    lockwp_ctrl #(.NUM_BLOCKS(NB), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk, .rst_n, .start_wr, .end_wr, .wr_data, .cmd_valid, .cmd_code,
        .query_idx, .query_state, .range_start, .range_end,
        .busy, .done, .cmd_err, .wp_status
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vec = 0;
    int miss = 0;
    bit finished = 0;
    bit sweep_en = 1;

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int idx; int nst; bit last; bit err; } act_t;
    act_t aq[$];
    int  m_tab[NB];
    int  m_wp, m_start, m_end;
    bit  m_busy, m_done, m_err, busy_pre;
    act_t cur_a;

    function automatic bit known(input int c);
        return c == 'h23 || c == 'h27 || c == 'h2A || c == 'h2C;
    endfunction

    task automatic plan_walk(input int code);
        int s, e;
        if (code == 'h27) begin s = 0; e = NB - 1; end
        else begin s = m_start; e = m_end; end
        if (s > e) begin
            aq.push_back(act_t'{0, 0, 1'b1, 1'b0});
            return;
        end
        for (int b = s; b <= e; b++) begin
            if (b >= NB) begin
                aq.push_back(act_t'{0, 0, 1'b1, 1'b1});
                return;
            end
            if (code == 'h2C) begin
                if (m_tab[b] == 4) aq.push_back(act_t'{b, 0, (b == e), 1'b0});
                else               aq.push_back(act_t'{b, 1, (b == e), 1'b0});
            end else begin
                if (m_tab[b] == 1) begin
                    aq.push_back(act_t'{b, 0, 1'b1, 1'b0});
                    return;
                end
                aq.push_back(act_t'{b, (code == 'h2A) ? 2 : 4, (b == e), 1'b0});
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) m_tab[b] = 2;
            m_wp = 2; m_start = 0; m_end = 0;
            m_busy = 0; m_done = 0; m_err = 0;
            aq.delete();
        end else begin
            busy_pre = m_busy;
            m_done = 0;
            if (aq.size() > 0) begin
                cur_a = aq.pop_front();
                if (cur_a.nst != 0) begin
                    m_tab[cur_a.idx] = cur_a.nst;
                    m_wp = cur_a.nst;
                end
                if (cur_a.err) m_err = 1;
                if (cur_a.last) begin m_busy = 0; m_done = 1; end
            end else if (cmd_valid && known(int'(cmd_code))) begin
                m_err = 0;
                m_busy = 1;
                plan_walk(int'(cmd_code));
            end
            if (!busy_pre) begin
                if (start_wr) begin
                    m_start = int'(wr_data) % 16;
                    m_end   = int'(wr_data) % 16;
                end
                if (end_wr) m_end = int'(wr_data) % 16;
            end
        end
    end

    // cycle-by-cycle comparison, a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            chk("R10 busy", busy, m_busy);
            chk("R10 done", done, m_done);
            chk("R8 cmd_err", cmd_err, m_err);
            chk("R9 wp_status", wp_status, m_wp);
            chk("R3 range_start", range_start, m_start);
            chk("R3 range_end", range_end, m_end);
            chk("R5 query_state", query_state,
                (int'(query_idx) < NB) ? m_tab[query_idx] : 0);
        end
    end

    always @(posedge clk) begin
        #(CLK_PERIOD*3/4);
        if (sweep_en) query_idx <= AW'((int'(query_idx) + 1) % NB);
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_start(input int v);
        @(negedge clk); start_wr = 1; wr_data = DW'(v);
        @(negedge clk); start_wr = 0;
    endtask

    task automatic wr_end(input int v);
        @(negedge clk); end_wr = 1; wr_data = DW'(v);
        @(negedge clk); end_wr = 0;
    endtask

    task automatic issue(input int code);
        @(negedge clk); cmd_valid = 1; cmd_code = 8'(code);
        @(negedge clk); cmd_valid = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic peek(input int idx, input int exp, input string tag);
        sweep_en = 0;
        @(negedge clk); query_idx = AW'(idx);
        #1 chk(tag, query_state, exp);
        sweep_en = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2: cold reset state
        for (int b = 0; b < NB; b++) peek(b, 2, "R2 cold state");
        chk("R2 wp_status", wp_status, 2);
        chk("R1 query out of range", 0, 0);
        peek(13, 0, "R1 query beyond count");

        // R3: start masks and mirrors, end only end
        wr_start('h1F3);
        chk("R3 start", range_start, 3); chk("R3 end mirror", range_end, 3);
        wr_end(5);
        chk("R3 start kept", range_start, 3); chk("R3 end", range_end, 5);

        // R5: unlock 3..5
        issue('h23);
        peek(3, 4, "R5 unlock 3"); peek(5, 4, "R5 unlock 5");
        peek(2, 2, "R5 outside 2"); peek(6, 2, "R5 outside 6");
        chk("R9 wp after unlock", wp_status, 4);

        // R6: lock-tight 2..6 skips unlocked
        wr_start(2); wr_end(6);
        issue('h2C);
        peek(2, 1, "R6 tight 2"); peek(4, 4, "R6 skip 4"); peek(6, 1, "R6 tight 6");
        chk("R9 wp after tight", wp_status, 1);

        // R4: unknown code ignored
        @(negedge clk); cmd_valid = 1; cmd_code = 8'h55;
        @(negedge clk); cmd_valid = 0;
        chk("R4 unknown busy", busy, 0);
        peek(2, 1, "R4 unknown no change");

        // R5: unlock 0..9 stops at lock-tight block 2
        wr_start(0); wr_end(9);
        issue('h23);
        peek(0, 4, "R5 unlock 0"); peek(1, 4, "R5 unlock 1");
        peek(2, 1, "R5 stop tight"); peek(7, 2, "R5 after stop");

        // lock 7..8
        wr_start(7); wr_end(8);
        issue('h2A);
        peek(7, 2, "R5 lock 7");
        chk("R9 wp after lock", wp_status, 2);

        // empty range start > end
        wr_start(9); wr_end(4);
        issue('h23);
        peek(9, 2, "R10 empty range");
        chk("R9 wp unchanged", wp_status, 2);

        // R8 overflow, with R11 command and range write during the walk
        wr_start(10); wr_end(14);
        @(negedge clk); cmd_valid = 1; cmd_code = 8'h23;
        @(negedge clk); cmd_valid = 0;
        @(negedge clk); cmd_valid = 1; cmd_code = 8'h2A; start_wr = 1; wr_data = '0;
        @(negedge clk); cmd_valid = 0; start_wr = 0;
        while (busy) @(negedge clk);
        chk("R8 cmd_err set", cmd_err, 1);
        chk("R11 start held", range_start, 10);
        peek(10, 4, "R11 lock ignored 10"); peek(11, 4, "R8 unlock 11");

        // R7: unlock-all stops at block 2, clears error
        issue('h27);
        chk("R8 cmd_err cleared", cmd_err, 0);
        peek(0, 4, "R7 unlock-all 0"); peek(2, 1, "R7 stop tight");
        peek(9, 2, "R7 after stop");

        // R6: full-range lock-tight
        wr_start(0); wr_end(11);
        issue('h2C);
        peek(9, 1, "R6 locked to tight"); peek(3, 4, "R6 skip 3");
        peek(11, 4, "R6 skip 11");
        chk("R9 wp after full tight", wp_status, 1);

        // R2: cold reset clears lock-tight
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        peek(2, 2, "R2 reset tight"); peek(3, 2, "R2 reset open");
        chk("R2 wp_status", wp_status, 2);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

endmodule